// File: doc/BRIEF.md
# I2C Address-Match Wakeup Controller

This block sits next to an I2C slave engine and provides a low-power wakeup mode. Software arms the mode through a small register port. While the mode is armed, the block waits for the engine to report an address match or a received extension code. It then raises a one-cycle interrupt and holds the bus in a wait state until software has disarmed the mode and released the wait. Stop-condition interrupts are suppressed while the mode is armed.

The block also shows the synchronized SCL and SDA levels in read-only status bits. It forwards master start requests. If software drops the arm bit before any match has been seen, the block blocks master start requests until the next start or stop condition appears on the bus. A request made during that window is dropped and recorded in a sticky error bit. The shift register, the address comparator and the bus drivers are outside the block and arrive as input pulses.

Register layout, written through `reg_we`/`reg_wdata` and read on `reg_rdata`:

| Bit | Field | Access |
|---|---|---|
| 0 | enable | read/write |
| 1 | arm | read/write |
| 2 | stop-interrupt enable | read/write |
| 3 | SCL level | read-only |
| 4 | SDA level | read-only |
| 5 | start error | write 1 to clear |
| 7:6 | unused | read 0 |

Top module: `i2c_wake_ctl`

## Requirements
- R1: After reset, `reg_rdata` reads 0, and `irq`, `wait_hold` and `start_go` are low while no start request is applied.
- R2: Writing 1 to the arm bit (bit 1) sets it only when the bus is idle and `is_master` is low. The bus is busy from any `start_det`, `addr_match` or `ext_code` pulse until the next `stop_det`. Writing 0 to the arm bit always clears it.
- R3: While enable (bit 0) is 1, an `addr_match` or `ext_code` pulse produces a one-cycle `irq` pulse in the following cycle. This happens whether or not the mode is armed. While enable is 0, these pulses produce no interrupt.
- R4: A `stop_det` pulse produces an `irq` pulse in the following cycle only when enable is 1, the stop-interrupt enable (bit 2) is 1 and the arm bit is 0.
- R5: While enable is 1, `wait_hold` rises the cycle after an `addr_match` or `ext_code` pulse. It falls the cycle after a `wait_release` pulse, but only if the arm bit is 0 at that pulse. A release while armed is ignored.
- R6: If the arm bit is cleared by a register write before any match or extension code has been seen while armed, `start_go` stays low until a `start_det` or `stop_det` pulse is seen. Otherwise `start_go` follows `start_req`.
- R7: A `start_req` made while start requests are blocked is dropped and sets the start error bit (bit 5). Writing 1 to bit 5 clears it. If a set and a clear fall in the same cycle, the set wins.
- R8: Bits 3 and 4 show `scl_in` and `sda_in` two clock edges after they are sampled, while enable is 1. They read 0 while enable is 0, and writes to them are ignored.
- R9: The stop-interrupt enable bit takes a written value only while enable is 0. The enable bit itself can always be written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| scl_in | input | 1 | Raw SCL level |
| sda_in | input | 1 | Raw SDA level |
| start_det | input | 1 | Start condition detected pulse |
| stop_det | input | 1 | Stop condition detected pulse |
| addr_match | input | 1 | Slave address match pulse |
| ext_code | input | 1 | Extension code received pulse |
| is_master | input | 1 | Engine currently operating as master |
| start_req | input | 1 | Master start request from the engine |
| wait_release | input | 1 | Software wait release pulse |
| start_go | output | 1 | Start request passed on to the engine |
| irq | output | 1 | One-cycle interrupt pulse |
| wait_hold | output | 1 | Holds the bus in a wait state |

## Verification
The hardest state to reach is a blocked master start. It needs three steps in order: an idle bus so that the arm bit can be set, then a disarm write with no match seen, then a start request before any bus condition arrives. Directed segments build this sequence and also the normal path, where a match comes first and the disarm leaves start requests open. A long random phase then mixes writes and bus pulses at low rates, so that arming, stop suppression and released waits overlap in many orders. A behavioural model is compared with the design on every cycle throughout.

// File: rtl/i2c_wake_ctl.sv
module i2c_wake_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic       addr_match,
  input  logic       ext_code,
  input  logic       is_master,
  input  logic       start_req,
  input  logic       wait_release,
  output logic       start_go,
  output logic       irq,
  output logic       wait_hold
);

  logic en, arm, spie, err, busy, matched, block;
  logic [1:0] scl_s, sda_s;
  logic irq_q, hold_q;

  wire hit        = addr_match | ext_code;
  wire idle       = ~busy & ~is_master;
  wire wr_arm_set = reg_we & reg_wdata[1] & ~arm & idle;
  wire wr_arm_clr = reg_we & ~reg_wdata[1] & arm;
  wire bad_disarm = wr_arm_clr & ~matched;
  wire bus_cond   = start_det | stop_det;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s <= '0;
      sda_s <= '0;
    end else begin
      scl_s <= {scl_s[0], scl_in};
      sda_s <= {sda_s[0], sda_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0;
      spie <= 1'b0;
      arm <= 1'b0;
    end else begin
      if (reg_we) begin
        en <= reg_wdata[0];
        if (!en) spie <= reg_wdata[2];
      end
      if (wr_arm_set) arm <= 1'b1;
      else if (wr_arm_clr) arm <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      matched <= 1'b0;
      block <= 1'b0;
      err <= 1'b0;
    end else begin
      if (stop_det) busy <= 1'b0;
      else if (start_det | hit) busy <= 1'b1;

      if (!arm || wr_arm_clr) matched <= 1'b0;
      else if (en & hit) matched <= 1'b1;

      if (bus_cond) block <= 1'b0;
      else if (bad_disarm) block <= 1'b1;

      if (start_req & block) err <= 1'b1;
      else if (reg_we & reg_wdata[5]) err <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      irq_q <= en & (hit | (stop_det & spie & ~arm));
      if (en & hit) hold_q <= 1'b1;
      else if (wait_release & ~arm) hold_q <= 1'b0;
    end
  end

  assign irq       = irq_q;
  assign wait_hold = hold_q;
  assign start_go  = start_req & ~block;
  assign reg_rdata = {2'b00, err, en & sda_s[1], en & scl_s[1], spie, arm, en};

endmodule

// File: rtl/i2c_wake_ctl_chk.sv
module i2c_wake_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       arm,
  input logic       block,
  input logic       err,
  input logic       stop_det,
  input logic       addr_match,
  input logic       ext_code,
  input logic       start_req,
  input logic       wait_release,
  input logic       start_go,
  input logic       irq,
  input logic       wait_hold,
  input logic [7:0] reg_rdata
);

  // R3
  irq_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(en && (addr_match || ext_code || stop_det)));

  // R4
  armed_stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && stop_det && !addr_match && !ext_code) |=> !irq);

  // R5
  hold_kept_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && wait_hold) |=> wait_hold);

  // R6
  blocked_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    block |-> !start_go);

  // R7
  drop_sets_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && block) |=> err);

  // R8
  level_zero_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (reg_rdata[4:3] == 2'b00));

endmodule

bind i2c_wake_ctl i2c_wake_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .arm(arm), .block(block), .err(err),
  .stop_det(stop_det), .addr_match(addr_match), .ext_code(ext_code),
  .start_req(start_req), .wait_release(wait_release), .start_go(start_go),
  .irq(irq), .wait_hold(wait_hold), .reg_rdata(reg_rdata)
);

// File: tb/i2c_wake_ctl_bench.sv
module i2c_wake_ctl_bench;
  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [7:0] reg_wdata = 0;
  logic scl_in = 0, sda_in = 0, start_det = 0, stop_det = 0;
  logic addr_match = 0, ext_code = 0, is_master = 0, start_req = 0, wait_release = 0;
  logic [7:0] reg_rdata;
  logic start_go, irq, wait_hold;
  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  i2c_wake_ctl u_i2c_wake_ctl (.*);

  // behavioural reference state
  int m_en, m_arm, m_spie, m_err, m_busy, m_seen, m_blk, m_irq, m_hold;
  int scl_q[$], sda_q[$];

  task automatic model_reset();
    m_en = 0; m_arm = 0; m_spie = 0; m_err = 0; m_busy = 0;
    m_seen = 0; m_blk = 0; m_irq = 0; m_hold = 0;
    scl_q = '{0, 0}; sda_q = '{0, 0};
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      int was_en, was_arm, ev, disarm, n_arm, n_seen;
      was_en = m_en; was_arm = m_arm;
      ev = (addr_match || ext_code) ? 1 : 0;
      disarm = (reg_we && !reg_wdata[1] && was_arm) ? 1 : 0;
      m_irq = (was_en && (ev || (stop_det && m_spie && !was_arm))) ? 1 : 0;
      if (was_en && ev) m_hold = 1;
      else if (wait_release && !was_arm) m_hold = 0;
      n_arm = was_arm;
      if (reg_we && reg_wdata[1] && !was_arm && !m_busy && !is_master) n_arm = 1;
      if (disarm) n_arm = 0;
      n_seen = m_seen;
      if (!was_arm || disarm) n_seen = 0;
      else if (was_en && ev) n_seen = 1;
      if (start_req && m_blk) m_err = 1;
      else if (reg_we && reg_wdata[5]) m_err = 0;
      if (start_det || stop_det) m_blk = 0;
      else if (disarm && !m_seen) m_blk = 1;
      if (stop_det) m_busy = 0;
      else if (start_det || ev) m_busy = 1;
      if (reg_we) begin
        if (!was_en) m_spie = reg_wdata[2];
        m_en = reg_wdata[0];
      end
      m_arm = n_arm; m_seen = n_seen;
      scl_q.push_back(scl_in); void'(scl_q.pop_front());
      sda_q.push_back(sda_in); void'(sda_q.pop_front());
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R3/R4 irq", irq, m_irq);
    chk("R5 wait_hold", wait_hold, m_hold);
    chk("R6 start_go", start_go, (start_req && !m_blk) ? 1 : 0);
    chk("R9 enable bit", reg_rdata[0], m_en);
    chk("R2 arm bit", reg_rdata[1], m_arm);
    chk("R9 stop-int enable bit", reg_rdata[2], m_spie);
    chk("R8 scl level", reg_rdata[3], m_en ? scl_q[0] : 0);
    chk("R8 sda level", reg_rdata[4], m_en ? sda_q[0] : 0);
    chk("R7 error bit", reg_rdata[5], m_err);
    chk("R1 unused bits", reg_rdata[7:6], 0);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
    reg_we = 0; start_det = 0; stop_det = 0; addr_match = 0;
    ext_code = 0; start_req = 0; wait_release = 0;
  endtask

  task automatic wr(input logic [7:0] d);
    reg_we = 1; reg_wdata = d; step();
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rdata", reg_rdata, 0);
    chk("R1 irq", irq, 0);
    chk("R1 wait_hold", wait_hold, 0);
    chk("R1 start_go", start_go, 0);
    rst_n = 1;
    step();
    // R9 stop-int enable takes effect while disabled, then locked
    wr(8'h04); wr(8'h05); wr(8'h01);
    // R8 levels follow pins through the synchronizer
    scl_in = 1; step(); step(); sda_in = 1; step(); step();
    // R2 arm refused while busy
    start_det = 1; step(); wr(8'h03);
    stop_det = 1; step();
    // R2 arm accepted when idle, R4 stop irq suppressed
    wr(8'h03); stop_det = 1; step(); step();
    // R3 R5 match while armed, release ignored while armed
    addr_match = 1; step(); wait_release = 1; step(); step();
    // normal disarm then release, R6 starts still pass
    wr(8'h01); wait_release = 1; step(); start_req = 1; step();
    // R6 R7 abnormal disarm blocks start, error set and cleared
    stop_det = 1; step(); wr(8'h03); wr(8'h01);
    start_req = 1; step(); step(); wr(8'h21);
    start_det = 1; step(); start_req = 1; step();
    // R3 extension code irq without arming; disabled gives none
    ext_code = 1; step(); step(); wr(8'h00); addr_match = 1; step(); step();
    // random mix
    for (int i = 0; i < 6000; i++) begin
      logic [7:0] r;
      r = 8'($urandom);
      reg_we = ($urandom % 8) == 0;
      reg_wdata = {r[7:1], ($urandom % 8) != 0 ? 1'b1 : r[0]};
      scl_in = $urandom; sda_in = $urandom;
      start_det = ($urandom % 16) == 0;
      stop_det = ($urandom % 14) == 0;
      addr_match = ($urandom % 20) == 0;
      ext_code = ($urandom % 40) == 0;
      is_master = ($urandom % 10) == 0;
      start_req = ($urandom % 6) == 0;
      wait_release = ($urandom % 8) == 0;
      step();
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule